// File: doc/BRIEF.md
# Vertex-to-Geometry Attribute Accumulator

This block sits between a vertex-processing stage and a geometry-processing stage. The vertex stage produces a fixed number of attribute vectors for each vertex. Each vector is 96 bits wide and holds four 24-bit floating-point components, which this block passes through unchanged. The block packs these vectors, in arrival order, into a single geometry input record. Once a vertex has delivered all of its attributes and the record holds the configured number of entries, the block presents the record to the geometry stage with a launch request and starts filling again from slot zero.

Two attribute counts are set by configuration. The number of entries in a geometry record is one field plus one. The number of attributes per vertex is another field plus one, and that field is supplied in two redundant copies. If the two copies disagree, the block raises a configuration error. If the record is already full while a vertex still has attributes to deliver, the extra attributes are dropped and an overflow pulse is raised. Each launch also carries a sticky flag. The flag is cleared at the start of a batch and becomes set at the first launch whose completing vertex has a nonzero vertex index.

Top module: `geo_rec_builder`

## Requirements
- R1: After reset, launch_valid is 0, attr_ready is 1, launch_flag is 0, and both error outputs are 0.
- R2: Each accepted attribute is written to record slot `fill` (slot i occupies bits i*ATTR_W+ATTR_W-1 down to i*ATTR_W), and `fill` then increments. Slot i of a launched record therefore holds the i-th attribute accepted since the previous launch or batch start.
- R3: err_cfg is 1 in the cycle after one in which cfg_vtx_a_m1 and cfg_vtx_b_m1 differ, and 0 in the cycle after one in which they are equal.
- R4: An attribute accepted while `fill` already equals the geometry count is not stored. err_ovf is then 1 for exactly one cycle, the cycle after acceptance.
- R5: When the last attribute of a vertex is accepted and `fill` has reached the geometry count, launch_valid is 1 from the next cycle and `fill` returns to zero.
- R6: At each launch the sticky flag is ORed with (vtx_index != 0), where vtx_index is the value presented with the vertex's last attribute. launch_flag shows the updated value from the launch cycle until the next launch.
- R7: batch_start clears `fill`, the position within the current vertex and the sticky flag. An attribute accepted in the same cycle is treated as the first of the new batch. A pending launch is not cancelled.
- R8: attr_ready is 0 while a launch is pending. launch_valid and the record hold steady until a cycle with launch_ready high.
- R9: The geometry count is cfg_geo_m1+1. The per-vertex count is cfg_vtx_a_m1+1, which sets the vertex boundaries even when the second copy differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_geo_m1 | input | CNT_W | Geometry record entry count minus one |
| cfg_vtx_a_m1 | input | CNT_W | Attributes per vertex minus one (primary copy) |
| cfg_vtx_b_m1 | input | CNT_W | Attributes per vertex minus one (redundant copy) |
| batch_start | input | 1 | Begins a new primitive batch |
| attr_valid | input | 1 | Attribute offered |
| attr_data | input | ATTR_W | Attribute vector (four opaque components) |
| vtx_index | input | IDX_W | Index of the vertex that owns the offered attribute |
| attr_ready | output | 1 | Attribute can be accepted |
| launch_valid | output | 1 | Geometry record ready to launch |
| launch_ready | input | 1 | Geometry stage takes the record |
| launch_flag | output | 1 | Sticky not-first-vertex flag |
| record | output | SLOTS*ATTR_W | Packed geometry input record |
| err_ovf | output | 1 | One-cycle pulse: attribute dropped |
| err_cfg | output | 1 | Vertex count copies disagree |

## Verification
The bench builds the block with its default parameters: 4-bit count fields, which give 16 record slots, 96-bit attributes and a 16-bit vertex index. With these values the extremes are reachable. A 1-entry record launches on every attribute. A 16-attribute vertex fills all 16 slots in one go. A 4-entry record fed by 3-attribute vertices takes the overflow path. Stalled launch handshakes, a batch start coinciding with an attribute, and disagreeing count copies are also driven. A behavioural model compares every output on every cycle.

// File: rtl/geo_rec_pkg.sv
package geo_rec_pkg;
    localparam int unsigned DEF_ATTR_W = 96;
    localparam int unsigned DEF_CNT_W  = 4;
    localparam int unsigned DEF_IDX_W  = 16;

    localparam int unsigned COMP_W = 24;
    typedef logic [COMP_W-1:0] comp_t;
endpackage

// File: rtl/geo_rec_cfgchk.sv
module geo_rec_cfgchk #(
    parameter int unsigned CNT_W = geo_rec_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] vtx_a_m1,
    input  logic [CNT_W-1:0] vtx_b_m1,
    output logic             err_cfg
);
    logic mism_d, mism_q;

    always_comb begin
        mism_d = (vtx_a_m1 != vtx_b_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mism_q <= 1'b0;
        else        mism_q <= mism_d;
    end

    assign err_cfg = mism_q;
endmodule

// File: rtl/geo_rec_store.sv
module geo_rec_store #(
    parameter int unsigned ATTR_W = geo_rec_pkg::DEF_ATTR_W,
    parameter int unsigned CNT_W  = geo_rec_pkg::DEF_CNT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [CNT_W-1:0]          wr_idx,
    input  logic [ATTR_W-1:0]         wr_data,
    output logic [(1<<CNT_W)*ATTR_W-1:0] record
);
    localparam int unsigned SLOTS = 1 << CNT_W;

    logic [ATTR_W-1:0] slot_d [SLOTS];
    logic [ATTR_W-1:0] slot_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_en && (wr_idx == CNT_W'(i))) slot_d[i] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end

        assign record[i*ATTR_W +: ATTR_W] = slot_q[i];
    end
endmodule

// File: rtl/geo_rec_ctrl.sv
module geo_rec_ctrl #(
    parameter int unsigned CNT_W = geo_rec_pkg::DEF_CNT_W,
    parameter int unsigned IDX_W = geo_rec_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             batch_start,
    input  logic [CNT_W-1:0] geo_m1,
    input  logic [CNT_W-1:0] vtx_m1,
    input  logic             attr_valid,
    input  logic [IDX_W-1:0] vtx_index,
    output logic             attr_ready,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_idx,
    output logic             launch_valid,
    input  logic             launch_ready,
    output logic             launch_flag,
    output logic             err_ovf
);
    localparam int unsigned FILL_W = CNT_W + 1;

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic [CNT_W-1:0]  vpos;
        logic              pend;
        logic              sticky;
        logic              flag;
        logic              ovf;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [FILL_W-1:0] geo_cnt;
    logic [FILL_W-1:0] base_fill;
    logic [FILL_W-1:0] fill_nx;
    logic [CNT_W-1:0]  base_vpos;
    logic              base_sticky;
    logic              fire;
    logic              room;
    logic              vtx_end;
    logic              sticky_nx;

    always_comb begin
        st_d        = st_q;
        st_d.ovf    = 1'b0;
        wr_en       = 1'b0;
        geo_cnt     = {1'b0, geo_m1} + FILL_W'(1);     // R9
        fire        = attr_valid && !st_q.pend;         // R8
        // R7: batch start acts before a same-cycle attribute
        base_fill   = batch_start ? '0   : st_q.fill;
        base_vpos   = batch_start ? '0   : st_q.vpos;
        base_sticky = batch_start ? 1'b0 : st_q.sticky;
        wr_idx      = base_fill[CNT_W-1:0];
        room        = base_fill < geo_cnt;
        vtx_end     = base_vpos == vtx_m1;
        fill_nx     = base_fill;
        sticky_nx   = base_sticky | (vtx_index != '0);

        st_d.fill   = base_fill;
        st_d.vpos   = base_vpos;
        st_d.sticky = base_sticky;

        if (st_q.pend && launch_ready) st_d.pend = 1'b0;

        if (fire) begin
            if (room) begin
                wr_en   = 1'b1;                          // R2
                fill_nx = base_fill + FILL_W'(1);
            end else begin
                st_d.ovf = 1'b1;                         // R4
            end
            st_d.vpos = vtx_end ? '0 : base_vpos + CNT_W'(1);
            if (vtx_end && (fill_nx >= geo_cnt)) begin
                st_d.pend   = 1'b1;                      // R5
                st_d.fill   = '0;
                st_d.sticky = sticky_nx;                 // R6
                st_d.flag   = sticky_nx;
            end else begin
                st_d.fill = fill_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign attr_ready   = !st_q.pend;
    assign launch_valid = st_q.pend;
    assign launch_flag  = st_q.flag;
    assign err_ovf      = st_q.ovf;
endmodule

// File: rtl/geo_rec_builder.sv
module geo_rec_builder #(
    parameter int unsigned ATTR_W = geo_rec_pkg::DEF_ATTR_W,
    parameter int unsigned CNT_W  = geo_rec_pkg::DEF_CNT_W,
    parameter int unsigned IDX_W  = geo_rec_pkg::DEF_IDX_W,
    localparam int unsigned SLOTS = 1 << CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cfg_geo_m1,
    input  logic [CNT_W-1:0]        cfg_vtx_a_m1,
    input  logic [CNT_W-1:0]        cfg_vtx_b_m1,
    input  logic                    batch_start,
    input  logic                    attr_valid,
    input  logic [ATTR_W-1:0]       attr_data,
    input  logic [IDX_W-1:0]        vtx_index,
    output logic                    attr_ready,
    output logic                    launch_valid,
    input  logic                    launch_ready,
    output logic                    launch_flag,
    output logic [SLOTS*ATTR_W-1:0] record,
    output logic                    err_ovf,
    output logic                    err_cfg
);
    logic             wr_en;
    logic [CNT_W-1:0] wr_idx;

    geo_rec_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .batch_start  (batch_start),
        .geo_m1       (cfg_geo_m1),
        .vtx_m1       (cfg_vtx_a_m1),
        .attr_valid   (attr_valid),
        .vtx_index    (vtx_index),
        .attr_ready   (attr_ready),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .launch_valid (launch_valid),
        .launch_ready (launch_ready),
        .launch_flag  (launch_flag),
        .err_ovf      (err_ovf)
    );

    geo_rec_store #(.ATTR_W(ATTR_W), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (attr_data),
        .record  (record)
    );

    geo_rec_cfgchk #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .vtx_a_m1 (cfg_vtx_a_m1),
        .vtx_b_m1 (cfg_vtx_b_m1),
        .err_cfg  (err_cfg)
    );
endmodule

// File: rtl/geo_rec_builder_chk.sv
module geo_rec_builder_chk #(
    parameter int unsigned ATTR_W = geo_rec_pkg::DEF_ATTR_W,
    parameter int unsigned CNT_W  = geo_rec_pkg::DEF_CNT_W
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [CNT_W-1:0]                 cfg_vtx_a_m1,
    input logic [CNT_W-1:0]                 cfg_vtx_b_m1,
    input logic                             attr_valid,
    input logic                             attr_ready,
    input logic                             launch_valid,
    input logic                             launch_ready,
    input logic [(1<<CNT_W)*ATTR_W-1:0]     record,
    input logic                             err_ovf,
    input logic                             err_cfg
);
    a_r8_ready_low_pending: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> !attr_ready);

    a_r8_launch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && !launch_ready) |=> launch_valid);

    a_r8_record_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && !launch_ready) |=> $stable(record));

    a_r3_cfg_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vtx_a_m1 != cfg_vtx_b_m1) |=> err_cfg);

    a_r3_cfg_same: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vtx_a_m1 == cfg_vtx_b_m1) |=> !err_cfg);

    a_r4_ovf_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |-> $past(attr_valid && attr_ready));

    a_r5_launch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(launch_valid) |-> $past(attr_valid && attr_ready));
endmodule

bind geo_rec_builder geo_rec_builder_chk #(.ATTR_W(ATTR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_vtx_a_m1 (cfg_vtx_a_m1),
    .cfg_vtx_b_m1 (cfg_vtx_b_m1),
    .attr_valid   (attr_valid),
    .attr_ready   (attr_ready),
    .launch_valid (launch_valid),
    .launch_ready (launch_ready),
    .record       (record),
    .err_ovf      (err_ovf),
    .err_cfg      (err_cfg)
);

// File: tb/geo_rec_builder_test.sv
`timescale 1ns/1ps
module geo_rec_builder_test;
    localparam int AW = 96;
    localparam int CW = 4;
    localparam int IW = 16;
    localparam int NS = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_geo_m1 = '0, cfg_vtx_a_m1 = '0, cfg_vtx_b_m1 = '0;
    logic          batch_start = 1'b0;
    logic          attr_valid = 1'b0;
    logic [AW-1:0] attr_data = '0;
    logic [IW-1:0] vtx_index = '0;
    logic          attr_ready, launch_valid, launch_flag, err_ovf, err_cfg;
    logic          launch_ready = 1'b1;
    logic [NS*AW-1:0] record;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    geo_rec_builder uut (
        .clk(clk), .rst_n(rst_n), .cfg_geo_m1(cfg_geo_m1), .cfg_vtx_a_m1(cfg_vtx_a_m1),
        .cfg_vtx_b_m1(cfg_vtx_b_m1), .batch_start(batch_start), .attr_valid(attr_valid),
        .attr_data(attr_data), .vtx_index(vtx_index), .attr_ready(attr_ready),
        .launch_valid(launch_valid), .launch_ready(launch_ready), .launch_flag(launch_flag),
        .record(record), .err_ovf(err_ovf), .err_cfg(err_cfg)
    );

    // behavioural reference model
    int m_fill, m_vpos, m_geo, m_vtx;
    bit m_pend, m_sticky, m_flag, m_ovf, m_cfg, m_fire;
    logic [AW-1:0] m_rec [NS];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_fill = 0; m_vpos = 0; m_pend = 0; m_sticky = 0; m_flag = 0; m_ovf = 0; m_cfg = 0;
            for (int i = 0; i < NS; i++) m_rec[i] = '0;
        end else begin
            m_geo = int'(cfg_geo_m1) + 1;
            m_vtx = int'(cfg_vtx_a_m1) + 1;
            m_cfg = (cfg_vtx_a_m1 != cfg_vtx_b_m1);
            m_ovf = 0;
            m_fire = attr_valid && !m_pend;
            if (m_pend && launch_ready) m_pend = 0;
            if (batch_start) begin m_fill = 0; m_vpos = 0; m_sticky = 0; end
            if (m_fire) begin
                if (m_fill < m_geo) begin m_rec[m_fill] = attr_data; m_fill++; end
                else m_ovf = 1;
                if (m_vpos == m_vtx - 1) begin
                    m_vpos = 0;
                    if (m_fill >= m_geo) begin
                        m_pend = 1; m_fill = 0;
                        m_sticky = m_sticky | (vtx_index != 0);
                        m_flag = m_sticky;
                    end
                end else m_vpos++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(launch_valid == m_pend, "R5 launch_valid", AW'(launch_valid), AW'(m_pend));
            chk(attr_ready == !m_pend, "R8 attr_ready", AW'(attr_ready), AW'(!m_pend));
            chk(launch_flag == m_flag, "R6 launch_flag", AW'(launch_flag), AW'(m_flag));
            chk(err_ovf == m_ovf, "R4 err_ovf", AW'(err_ovf), AW'(m_ovf));
            chk(err_cfg == m_cfg, "R3 err_cfg", AW'(err_cfg), AW'(m_cfg));
            if (m_pend)
                for (int i = 0; i < NS; i++)
                    if (i < m_geo)
                        chk(record[i*AW +: AW] == m_rec[i], "R2 record slot",
                            record[i*AW +: AW], m_rec[i]);
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            launch_ready = stall ? (cyc % 4 == 3) : 1'b1;
        end
    end

    int seq = 0;
    task automatic send(input int idx);
        bit acc;
        seq++;
        attr_data  = {32'(seq) ^ 32'hC0DE0000, 32'(seq * 7), 32'(seq) + 32'h11};
        vtx_index  = IW'(idx);
        attr_valid = 1'b1;
        do begin
            @(negedge clk); acc = attr_ready;
            @(posedge clk); #1;
            batch_start = 1'b0;
        end while (!acc);
        attr_valid = 1'b0;
    endtask

    task automatic vertex(input int idx, input int n);
        for (int k = 0; k < n; k++) send(idx);
    endtask

    task automatic cfg(input int g, input int va, input int vb);
        cfg_geo_m1 = CW'(g - 1); cfg_vtx_a_m1 = CW'(va - 1); cfg_vtx_b_m1 = CW'(vb - 1);
    endtask

    task automatic new_batch();
        @(posedge clk); #1; batch_start = 1'b1;
        @(posedge clk); #1; batch_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        cfg(6, 2, 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(launch_valid == 0, "R1 launch_valid", AW'(launch_valid), 0);
        chk(attr_ready == 1, "R1 attr_ready", AW'(attr_ready), 1);
        chk(launch_flag == 0, "R1 launch_flag", AW'(launch_flag), 0);
        chk(err_ovf == 0 && err_cfg == 0, "R1 errors", AW'({err_ovf, err_cfg}), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(2);

        // 6-entry record from 2-attribute vertices
        vertex(0, 2); vertex(1, 2); vertex(2, 2);
        chk(launch_valid == 1, "R5 launch after third vertex", AW'(launch_valid), 1);
        idle(3);

        // R6: geo == vtx, flag low on vertex 0, then sticky
        new_batch();
        cfg(3, 3, 3);
        vertex(0, 3);
        chk(launch_flag == 0, "R6 first vertex flag", AW'(launch_flag), 0);
        vertex(1, 3);
        vertex(0, 3);
        chk(launch_flag == 1, "R6 flag stays set", AW'(launch_flag), 1);
        new_batch();
        vertex(0, 3);
        chk(launch_flag == 0, "R7 flag cleared by batch start", AW'(launch_flag), 0);
        idle(2);

        // R4: 4-entry record, 3-attribute vertices
        new_batch();
        cfg(4, 3, 3);
        vertex(5, 3);
        chk(launch_valid == 0, "R5 no launch at 3 of 4", AW'(launch_valid), 0);
        vertex(6, 3);
        idle(3);

        // extremes: 16/16 and 1/1
        new_batch();
        cfg(16, 16, 16);
        vertex(1, 16);
        chk(launch_valid == 1, "R5 full record", AW'(launch_valid), 1);
        idle(2);
        cfg(1, 1, 1);
        for (int v = 0; v < 6; v++) vertex(v, 1);
        idle(2);

        // stalled handshake
        stall = 1'b1;
        cfg(2, 1, 1);
        for (int v = 0; v < 8; v++) vertex(v, 1);
        idle(6);
        stall = 1'b0;
        idle(2);

        // R9 / R3: copies disagree, primary sets vertex boundaries
        new_batch();
        cfg(2, 2, 4);
        vertex(3, 2);
        chk(launch_valid == 1, "R9 primary count used", AW'(launch_valid), 1);
        chk(err_cfg == 1, "R3 mismatch flagged", AW'(err_cfg), 1);
        cfg(2, 2, 2);
        idle(2);
        chk(err_cfg == 0, "R3 mismatch cleared", AW'(err_cfg), 0);

        // R7: batch start in same cycle as an attribute, mid-record
        cfg(4, 1, 1);
        vertex(0, 2);
        @(posedge clk); #1;
        batch_start = 1'b1;
        send(0);
        vertex(0, 3);
        chk(launch_valid == 1, "R7 new batch counts same-cycle attribute", AW'(launch_valid), 1);
        // R7: batch start does not cancel pending launch
        stall = 1'b1;
        new_batch();
        chk(launch_valid == 1 || m_pend == 0, "R7 pending kept", AW'(launch_valid), AW'(m_pend));
        stall = 1'b0;
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule